// File: doc/BRIEF.md
# Width-Adaptive Byte FIFO Port

This block sits between a processor register port and a card link that moves one byte at a time. It holds two 32-entry byte queues. The receive queue is filled one byte at a time from the card side. The processor drains it with reads that are 1, 2 or 4 bytes wide. The transmit queue is filled by processor writes of the same widths. The card side empties it one byte per handshake.

Within one access, bytes are packed with the oldest byte in the highest lane used by that width. A transfer counter is loaded with the total byte count of a transfer. It is reduced by one for every byte that crosses the card side, and card-side movement stops when it reaches zero. A direction level selects which queue the card side serves.

The block raises two service requests:
- a receive request, raised when a byte arrives from the card;
- a transmit request, raised while the transfer still wants bytes.

A flush strobe with data bit 0 set discards whatever is waiting in the transmit queue.

Top module: `byte_fifo_port`

## Requirements
- R1: After reset:
  - both queues are empty;
  - the transfer counter is 0;
  - `rx_req`, `tx_req`, `card_rx_ready` and `card_tx_valid` are 0;
  - `cpu_rdata` is 0.
- R2: The width code on `cpu_width` gives the number of bytes N for an access: 0 means N=1, 1 means N=2, 2 or 3 means N=4. A read with `cpu_rd_en` pops min(N, fill) bytes in the same cycle that `cpu_rdata` shows them. The first popped byte sits in lane N-1 (bits 8*(N-1)+7 down to 8*(N-1)). Each later byte sits one lane lower.
- R3: Lanes of `cpu_rdata` that are not filled by a popped byte read as zero. This includes the lanes at and above N and the lanes left over when the queue runs dry. A read of an empty queue returns 0 and leaves later data order intact.
- R4: A write with `cpu_wr_en` and width N pushes the bytes of `cpu_wdata`, starting from lane N-1 and moving down. It stops once the transmit queue holds 32 bytes. Bytes beyond that point are dropped, and the queued data is not disturbed.
- R5: `card_rx_ready` is 1 exactly when all three hold: `xfer_dir` is 0, the counter is nonzero, and the receive queue holds fewer than 32 bytes. A byte is taken only when `card_rx_valid` and `card_rx_ready` are both 1.
- R6: `card_tx_valid` is 1 exactly when all three hold: `xfer_dir` is 1, the counter is nonzero, and the transmit queue is not empty. `card_tx_data` is the oldest queued byte, and it is removed when `card_tx_ready` is 1.
- R7: A pulse on `xfer_load` sets the counter to `xfer_bytes` on the next cycle. Otherwise, every byte that crosses the card side lowers the counter by one.
- R8: `rx_req` becomes 1 on the cycle after any byte is taken from the card. It returns to 0 after a processor read in a cycle in which no card byte is taken.
- R9: `tx_req` is 1 exactly when `xfer_dir` is 1 and the counter is nonzero.
- R10: A `cpu_flush_wr` pulse with `cpu_wdata[0]` = 1 empties the transmit queue. With `cpu_wdata[0]` = 0 the pulse has no effect.
- R11: Both queues keep byte order across the wrap of their 32-entry index space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_width | input | 2 | Access width code (0:1 byte, 1:2 bytes, 2/3:4 bytes) |
| cpu_rd_en | input | 1 | Processor read of the receive data location |
| cpu_rdata | output | 32 | Packed read data for the current access |
| cpu_wr_en | input | 1 | Processor write of the transmit data location |
| cpu_wdata | input | 32 | Write data, also carries the flush bit |
| cpu_flush_wr | input | 1 | Write strobe of the partial-buffer location |
| xfer_load | input | 1 | Load the transfer counter |
| xfer_dir | input | 1 | 0: card to processor, 1: processor to card |
| xfer_bytes | input | 16 | Transfer length loaded by `xfer_load` |
| xfer_remaining | output | 16 | Bytes still to cross the card side |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Offered byte |
| card_rx_ready | output | 1 | Receive queue accepts a byte |
| card_tx_valid | output | 1 | Transmit byte available |
| card_tx_data | output | 8 | Oldest transmit byte |
| card_tx_ready | input | 1 | Card takes the transmit byte |
| rx_req | output | 1 | Receive service request |
| tx_req | output | 1 | Transmit service request |

## Verification
The assertions assume several things about the inputs:
- `cpu_rd_en`, `cpu_wr_en` and `cpu_flush_wr` are never asserted in the same cycle;
- `xfer_dir` does not change while bytes are in flight;
- the card side holds `card_rx_valid` or `card_tx_ready` for a single cycle per byte.

The stimulus follows these rules by driving each processor access as one isolated cycle. It changes direction only after both queues are drained and a new count is loaded. Fill levels 0 to 5 are swept against every width, and a 40-byte stream is run so the receive index wraps.

// File: rtl/byte_fifo_port.sv
module byte_fifo_port #(
  parameter int DEPTH_LOG2 = 5,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cpu_width,
  input  logic             cpu_rd_en,
  output logic [31:0]      cpu_rdata,
  input  logic             cpu_wr_en,
  input  logic [31:0]      cpu_wdata,
  input  logic             cpu_flush_wr,
  input  logic             xfer_load,
  input  logic             xfer_dir,
  input  logic [CNT_W-1:0] xfer_bytes,
  output logic [CNT_W-1:0] xfer_remaining,
  input  logic             card_rx_valid,
  input  logic [7:0]       card_rx_data,
  output logic             card_rx_ready,
  output logic             card_tx_valid,
  output logic [7:0]       card_tx_data,
  input  logic             card_tx_ready,
  output logic             rx_req,
  output logic             tx_req
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int PW    = DEPTH_LOG2;
  localparam int CW    = DEPTH_LOG2 + 1;

  logic [7:0]       rx_mem [DEPTH];
  logic [7:0]       tx_mem [DEPTH];
  logic [PW-1:0]    rx_rd, rx_wr, tx_rd, tx_wr;
  logic [CW-1:0]    rx_cnt, tx_cnt;
  logic [CNT_W-1:0] remain;
  logic             rx_req_q;

  logic [2:0]    nb;
  logic [CW-1:0] nbw, rx_take, rx_pop, tx_space, tx_push;
  logic          rx_acc, tx_pop, do_flush, more;

  assign nb       = (cpu_width == 2'd0) ? 3'd1 : (cpu_width == 2'd1) ? 3'd2 : 3'd4;
  assign nbw      = CW'(nb);
  assign more     = (remain != '0);
  assign rx_take  = (rx_cnt < nbw) ? rx_cnt : nbw;
  assign rx_pop   = cpu_rd_en ? rx_take : '0;
  assign tx_space = CW'(DEPTH) - tx_cnt;
  assign tx_push  = cpu_wr_en ? ((tx_space < nbw) ? tx_space : nbw) : '0;
  assign do_flush = cpu_flush_wr & cpu_wdata[0];

  assign card_rx_ready  = ~xfer_dir & more & (rx_cnt < CW'(DEPTH));
  assign rx_acc         = card_rx_valid & card_rx_ready;
  assign card_tx_valid  = xfer_dir & more & (tx_cnt != '0);
  assign tx_pop         = card_tx_valid & card_tx_ready;
  assign card_tx_data   = tx_mem[tx_rd];
  assign xfer_remaining = remain;
  assign rx_req         = rx_req_q;
  assign tx_req         = xfer_dir & more;

  always_comb begin
    cpu_rdata = '0;
    for (int i = 0; i < 4; i++) begin
      if (CW'(i) < rx_take)
        cpu_rdata[8*(int'(nb)-1-i) +: 8] = rx_mem[PW'(rx_rd + PW'(i))];
    end
  end

  always_ff @(posedge clk) begin
    if (rx_acc) rx_mem[rx_wr] <= card_rx_data;
    for (int i = 0; i < 4; i++) begin
      if (CW'(i) < tx_push)
        tx_mem[PW'(tx_wr + PW'(i))] <= cpu_wdata[8*(int'(nb)-1-i) +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_rd    <= '0;
      rx_wr    <= '0;
      rx_cnt   <= '0;
      tx_rd    <= '0;
      tx_wr    <= '0;
      tx_cnt   <= '0;
      remain   <= '0;
      rx_req_q <= 1'b0;
    end else begin
      rx_wr  <= rx_wr + PW'(rx_acc);
      rx_rd  <= rx_rd + PW'(rx_pop);
      rx_cnt <= rx_cnt + CW'(rx_acc) - rx_pop;
      if (rx_acc) rx_req_q <= 1'b1;
      else if (cpu_rd_en) rx_req_q <= 1'b0;

      if (do_flush) begin
        tx_rd  <= tx_wr;
        tx_cnt <= '0;
      end else begin
        tx_wr  <= tx_wr + PW'(tx_push);
        tx_rd  <= tx_rd + PW'(tx_pop);
        tx_cnt <= tx_cnt + tx_push - CW'(tx_pop);
      end

      if (xfer_load) remain <= xfer_bytes;
      else if (rx_acc | tx_pop) remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/byte_fifo_port_chk.sv
module byte_fifo_port_chk #(
  parameter int DEPTH_LOG2 = 5,
  parameter int CNT_W      = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_rd_en,
  input logic             cpu_flush_wr,
  input logic             cpu_wdata0,
  input logic             xfer_load,
  input logic             xfer_dir,
  input logic [CNT_W-1:0] xfer_bytes,
  input logic [CNT_W-1:0] xfer_remaining,
  input logic             card_rx_valid,
  input logic             card_rx_ready,
  input logic             card_tx_valid,
  input logic             card_tx_ready,
  input logic             rx_req,
  input logic [DEPTH_LOG2:0] rx_cnt,
  input logic [DEPTH_LOG2:0] tx_cnt
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  a_r5_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
    card_rx_ready |-> (xfer_remaining != '0) && !xfer_dir);
  a_r5_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= (DEPTH_LOG2+1)'(DEPTH));
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= (DEPTH_LOG2+1)'(DEPTH));
  a_r6_tx_gate: assert property (@(posedge clk) disable iff (!rst_n)
    card_tx_valid |-> (xfer_remaining != '0) && xfer_dir);
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_load && ((card_rx_valid && card_rx_ready) || (card_tx_valid && card_tx_ready)))
    |=> xfer_remaining == CNT_W'($past(xfer_remaining) - 1'b1));
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_load |=> xfer_remaining == $past(xfer_bytes));
  a_r8_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_req) |-> $past(card_rx_valid && card_rx_ready));
  a_r8_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_req) |-> $past(cpu_rd_en));
  a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_flush_wr && cpu_wdata0) |=> !card_tx_valid);
endmodule

bind byte_fifo_port byte_fifo_port_chk #(.DEPTH_LOG2(DEPTH_LOG2), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rd_en(cpu_rd_en), .cpu_flush_wr(cpu_flush_wr),
  .cpu_wdata0(cpu_wdata[0]), .xfer_load(xfer_load), .xfer_dir(xfer_dir),
  .xfer_bytes(xfer_bytes), .xfer_remaining(xfer_remaining),
  .card_rx_valid(card_rx_valid), .card_rx_ready(card_rx_ready),
  .card_tx_valid(card_tx_valid), .card_tx_ready(card_tx_ready),
  .rx_req(rx_req), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt)
);

// File: tb/tb_byte_fifo_port.sv
module tb_byte_fifo_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cpu_width = '0;
  logic        cpu_rd_en = 1'b0, cpu_wr_en = 1'b0, cpu_flush_wr = 1'b0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic        xfer_load = 1'b0, xfer_dir = 1'b0;
  logic [15:0] xfer_bytes = '0, xfer_remaining;
  logic        card_rx_valid = 1'b0, card_rx_ready;
  logic [7:0]  card_rx_data = '0, card_tx_data;
  logic        card_tx_valid, card_tx_ready = 1'b0;
  logic        rx_req, tx_req;

  int checks = 0, errors = 0;
  logic [7:0] rq[$];
  logic [7:0] tq[$];
  int rem = 0;
  int seed = 1;

  always #4 clk = ~clk;

  byte_fifo_port dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nbytes(logic [1:0] w);
    return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
  endfunction

  task automatic load(int n, logic dir);
    xfer_dir = dir; xfer_bytes = 16'(n); xfer_load = 1'b1;
    @(negedge clk); xfer_load = 1'b0; rem = n;
    #1 chk("R7 load", 32'(xfer_remaining), 32'(n));
    chk("R9 tx_req", 32'(tx_req), 32'(dir && n != 0));
  endtask

  task automatic card_rx(logic [7:0] b);
    logic exp_rdy;
    card_rx_valid = 1'b1; card_rx_data = b;
    exp_rdy = !xfer_dir && rem != 0 && rq.size() < 32;
    #1 chk("R5 rx ready", 32'(card_rx_ready), 32'(exp_rdy));
    if (exp_rdy) begin rq.push_back(b); rem--; end
    @(negedge clk); card_rx_valid = 1'b0;
    #1 chk("R7 rx count", 32'(xfer_remaining), 32'(rem));
    if (exp_rdy) chk("R8 rx_req set", 32'(rx_req), 32'd1);
  endtask

  task automatic cpu_read(logic [1:0] w);
    logic [31:0] e = '0;
    int n = nbytes(w);
    for (int i = 0; i < n; i++)
      if (rq.size() > 0) e[8*(n-1-i) +: 8] = rq.pop_front();
    cpu_width = w; cpu_rd_en = 1'b1;
    #1 chk("R2 R3 read packing", cpu_rdata, e);
    @(negedge clk); cpu_rd_en = 1'b0;
    #1 chk("R8 rx_req clear", 32'(rx_req), 32'd0);
  endtask

  task automatic cpu_write(logic [1:0] w, logic [31:0] d);
    int n = nbytes(w);
    for (int i = 0; i < n; i++)
      if (tq.size() < 32) tq.push_back(d[8*(n-1-i) +: 8]);
    cpu_width = w; cpu_wdata = d; cpu_wr_en = 1'b1;
    @(negedge clk); cpu_wr_en = 1'b0;
  endtask

  task automatic flush(logic bit0);
    cpu_wdata = {31'd0, bit0}; cpu_flush_wr = 1'b1;
    if (bit0) tq.delete();
    @(negedge clk); cpu_flush_wr = 1'b0;
  endtask

  task automatic drain_one();
    logic exp_v = xfer_dir && rem != 0 && tq.size() > 0;
    card_tx_ready = 1'b1;
    #1 chk("R6 tx valid", 32'(card_tx_valid), 32'(exp_v));
    if (exp_v) begin
      chk("R4 R11 tx data", 32'(card_tx_data), 32'(tq.pop_front()));
      rem--;
    end
    @(negedge clk); card_tx_ready = 1'b0;
    #1 chk("R7 tx count", 32'(xfer_remaining), 32'(rem));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 rx_req", 32'(rx_req), 0);
    chk("R1 tx_req", 32'(tx_req), 0);
    chk("R1 count", 32'(xfer_remaining), 0);
    chk("R1 tx_valid", 32'(card_tx_valid), 0);
    chk("R1 rx_ready", 32'(card_rx_ready), 0);
    chk("R1 rdata", cpu_rdata, 0);

    // R5 R11: 40-byte receive stream fills to 32, then wraps
    load(40, 1'b0);
    for (int k = 0; k < 33; k++) card_rx(8'(k*7 + 3));
    chk("R5 full", 32'(card_rx_ready), 0);
    for (int k = 0; k < 6; k++) cpu_read(2'(k % 3));
    for (int k = 0; k < 12; k++) card_rx(8'(k*13 + 100));
    chk("R5 count zero", 32'(card_rx_ready), 0);
    while (rq.size() > 0) cpu_read(2'd2);
    cpu_read(2'd2);
    cpu_read(2'd0);

    // R2 R3: sweep width x fill level
    for (int w = 0; w < 4; w++)
      for (int c = 0; c < 6; c++) begin
        load(c, 1'b0);
        for (int k = 0; k < c + 2; k++) card_rx(8'(w*40 + c*6 + k + 1));
        cpu_read(2'(w));
        cpu_read(2'd2);
        cpu_read(2'd2);
      end

    // R4 R6 R9: transmit fill to capacity then drain
    load(100, 1'b1);
    cpu_write(2'd1, 32'h0000_A1B2);
    cpu_write(2'd0, 32'h0000_00C3);
    for (int k = 0; k < 8; k++) cpu_write(2'd2, 32'h1020_3040 + 32'(k) * 32'h0101_0101);
    cpu_write(2'd0, 32'h0000_00EE);
    chk("R4 model full", 32'(tq.size()), 32);
    for (int k = 0; k < 33; k++) drain_one();

    // R10: flush behaviour
    cpu_write(2'd2, 32'hDEAD_BEEF);
    flush(1'b0);
    drain_one();
    flush(1'b1);
    drain_one();
    cpu_write(2'd1, 32'h0000_ABCD);
    drain_one(); drain_one(); drain_one();

    // R6 R9: counter ends mid-queue
    load(3, 1'b1);
    cpu_write(2'd3, 32'h5566_7788);
    for (int k = 0; k < 4; k++) drain_one();
    chk("R9 tx_req end", 32'(tx_req), 0);
    flush(1'b1);
    load(2, 1'b1);
    drain_one();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule